// File: doc/BRIEF.md
# Two-Wire Serial Register-File Slave

A slave on the two-wire I2C serial bus that lets a host controller read and write a bank of 8-bit registers. The block runs from a fast system clock that oversamples both bus lines. Each line first passes through a two-flop synchronizer and a glitch filter, which rejects short spikes. Edge and condition detectors then find SCL rising and falling edges, START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high). A byte engine shifts in a 7-bit device address plus a direction bit and compares the address with one of two fixed values, chosen by a select pin.

In a write transfer, the first byte after the address loads a register pointer, and every later byte is stored at the pointer, which then advances. A read transfer returns bytes starting at the current pointer, MSB first, and advances the pointer after each byte. A NACK from the master ends the read.

The SDA output is an active-low drive enable. A 1 releases the line, so the bus behaves as open-drain. A repeated START is allowed at any point. It makes the common sequence possible: write the pointer, then issue a repeated START and read back from that pointer.

Top module: `i2c_regfile_slave`

## Requirements
- R1: After reset the SDA drive is released (`sda_drv_no`=1) and every register reads as 0x00.
- R2: The slave acknowledges (pulls SDA low during the ninth clock) an address byte whose upper seven bits are 0x3A when `addr_sel_i`=0, or 0x3B when `addr_sel_i`=1. The direction bit is byte bit 0, with 1 meaning read.
- R3: After an address that does not match, the slave acknowledges nothing and writes nothing until the next START.
- R4: In a write transfer, the byte after the address sets the pointer. Each later byte is acknowledged, stored at the pointer, and followed by a pointer increment.
- R5: A read transfer sends the register at the current pointer MSB first, increments the pointer after each byte it sends, and therefore continues from wherever the last access left the pointer.
- R6: A NACK from the master after a read byte makes the slave release SDA and stay silent until the next START, even if the clock keeps running.
- R7: A repeated START with no STOP before it begins a new transfer with a fresh address byte.
- R8: A STOP returns the slave to idle with SDA released. A data byte cut short by a STOP is not written.
- R9: A pulse on SCL or SDA shorter than `FILT_CYCLES` system clocks (52 ns by default) has no effect on the transfer.
- R10: Only the low `AW` bits of the pointer byte are used, and the pointer wraps from 2^AW-1 to 0.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel_i | input | 1 | Picks device address 0x3A (0) or 0x3B (1) |
| sda_drv_no | output | 1 | SDA drive enable, active low; 1 releases the line |

## Verification
A wrong internal state shows up at `sda_drv_no` within one bus bit time. If the byte counter has slipped, the acknowledge lands in the wrong clock or goes missing, and the acknowledge check sees it in the ninth clock of the same byte. If the state is wrong after a START or STOP, the slave drives the line when it should not, or stays silent when it should answer. A wrong pointer is only visible later, when read data arrives from the wrong register. For that reason, every write is followed by a read-back through the bus.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } slv_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } rx_kind_e;
endpackage

// File: rtl/i2c_spike_filter.sv
module i2c_spike_filter #(
  parameter int FILT_CYCLES = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(FILT_CYCLES - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      cnt_q  <= '0;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == line_o) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_MAX) begin
        cnt_q  <= '0;
        line_o <= sync_q[1];
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R9
  filt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> $past(cnt_q) == CNT_MAX);
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[g] <= '0;
      else if (we_i && addr_i == AW'(g))      mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_slv_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [6:0]        dev_addr_i,
  output logic              reg_we_o,
  output logic [AW-1:0]     reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  input  logic [BYTE_W-1:0] reg_rdata_i,
  output logic              sda_drv_no
);
  slv_state_e        state_q;
  rx_kind_e          kind_q;
  logic [BIT_CW-1:0] bitcnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q;
  logic [AW-1:0]     ptr_q;
  logic              rw_q;
  logic              byte_end;

  assign byte_end = (state_q == ST_RX) && scl_fall_i && (bitcnt_q == BIT_CW'(BYTE_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      kind_q     <= K_ADDR;
      bitcnt_q   <= '0;
      rx_q       <= '0;
      tx_q       <= '0;
      ptr_q      <= '0;
      rw_q       <= 1'b0;
      sda_drv_no <= 1'b1;
    end else if (start_i) begin
      state_q    <= ST_RX;
      kind_q     <= K_ADDR;
      bitcnt_q   <= '0;
      sda_drv_no <= 1'b1;
    end else if (stop_i) begin
      state_q    <= ST_IDLE;
      sda_drv_no <= 1'b1;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise_i && bitcnt_q < BIT_CW'(BYTE_W)) begin
            rx_q     <= {rx_q[BYTE_W-2:0], sda_lvl_i};
            bitcnt_q <= bitcnt_q + 1'b1;
          end
          if (byte_end) begin
            unique case (kind_q)
              K_ADDR: begin
                if (rx_q[7:1] == dev_addr_i) begin
                  rw_q       <= rx_q[0];
                  sda_drv_no <= 1'b0;
                  state_q    <= ST_RX_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              K_PTR: begin
                ptr_q      <= rx_q[AW-1:0];
                sda_drv_no <= 1'b0;
                state_q    <= ST_RX_ACK;
              end
              default: begin
                ptr_q      <= ptr_q + 1'b1;
                sda_drv_no <= 1'b0;
                state_q    <= ST_RX_ACK;
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall_i) begin
            bitcnt_q <= '0;
            if (kind_q == K_ADDR && rw_q) begin
              state_q    <= ST_TX;
              tx_q       <= reg_rdata_i;
              sda_drv_no <= reg_rdata_i[BYTE_W-1];
              ptr_q      <= ptr_q + 1'b1;
            end else begin
              state_q    <= ST_RX;
              sda_drv_no <= 1'b1;
              kind_q     <= (kind_q == K_ADDR) ? K_PTR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall_i) begin
            if (bitcnt_q == BIT_CW'(BYTE_W - 1)) begin
              sda_drv_no <= 1'b1;
              state_q    <= ST_TX_ACK;
            end else begin
              tx_q       <= {tx_q[BYTE_W-2:0], 1'b0};
              sda_drv_no <= tx_q[BYTE_W-2];
              bitcnt_q   <= bitcnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i && sda_lvl_i) begin
            state_q <= ST_IDLE;
          end else if (scl_fall_i) begin
            state_q    <= ST_TX;
            bitcnt_q   <= '0;
            tx_q       <= reg_rdata_i;
            sda_drv_no <= reg_rdata_i[BYTE_W-1];
            ptr_q      <= ptr_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign reg_we_o    = byte_end && (kind_q == K_DATA) && !start_i && !stop_i;
  assign reg_addr_o  = ptr_q;
  assign reg_wdata_o = rx_q;

  // R7
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_RX && kind_q == K_ADDR && bitcnt_q == '0));

  // R8
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (state_q == ST_IDLE && sda_drv_no));

  // R3
  mismatch_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_end && kind_q == K_ADDR && rx_q[7:1] != dev_addr_i && !start_i && !stop_i)
      |=> (state_q == ST_IDLE && sda_drv_no));

  // R6
  nack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX_ACK && scl_rise_i && sda_lvl_i && !start_i && !stop_i)
      |=> (state_q == ST_IDLE && sda_drv_no));

  // R11
  drv_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_drv_no) && !$past(start_i) && !$past(stop_i)) |-> !scl_lvl_i);
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave
  import i2c_slv_pkg::*;
#(
  parameter int         AW          = 4,
  parameter int         FILT_CYCLES = 13,
  parameter logic [6:0] DEV_ADDR    = 7'h3A
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic addr_sel_i,
  output logic sda_drv_no
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, flt_lines;
  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic reg_we;
  logic [AW-1:0]     reg_addr;
  logic [BYTE_W-1:0] reg_wdata, reg_rdata;
  logic [6:0]        dev_addr;

  assign raw_lines = {sda_i, scl_i};
  assign dev_addr  = {DEV_ADDR[6:1], addr_sel_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_spike_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[g]),
      .line_o(flt_lines[g])
    );
  end

  i2c_bus_events u_events (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (flt_lines[0]),
    .sda_i     (flt_lines[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  i2c_slave_fsm #(.AW(AW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_lvl_i  (flt_lines[0]),
    .sda_lvl_i  (flt_lines[1]),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_ev),
    .stop_i     (stop_ev),
    .dev_addr_i (dev_addr),
    .reg_we_o   (reg_we),
    .reg_addr_o (reg_addr),
    .reg_wdata_o(reg_wdata),
    .reg_rdata_i(reg_rdata),
    .sda_drv_no (sda_drv_no)
  );

  i2c_reg_bank #(.AW(AW), .DW(BYTE_W)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we),
    .addr_i (reg_addr),
    .wdata_i(reg_wdata),
    .rdata_o(reg_rdata)
  );
endmodule

// File: tb/sim_i2c_regfile_slave.sv
module sim_i2c_regfile_slave;
  localparam int Q  = 63;
  localparam int WD = 195000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, sel = 1'b0;
  logic sda_drv_n;
  logic sda_bus;
  int checks = 0, fails = 0, r11_viol = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & sda_drv_n;

  i2c_regfile_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel_i(sel), .sda_drv_no(sda_drv_n)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R11 monitor: drive must not change while SCL is high
  logic scl_p = 1'b1, drv_p = 1'b1;
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_p && sda_drv_n != drv_p) r11_viol++;
    scl_p = scl_m;
    drv_p = sda_drv_n;
  end

  task automatic bit_x(input logic b, input logic g, output logic s);
    sda_m = b;
    if (g) begin w(20); scl_m = 1'b1; w(10); scl_m = 1'b0; w(Q - 30); end
    else w(Q);
    scl_m = 1'b1;
    if (g) begin w(20); sda_m = ~b; w(10); sda_m = b; w(Q - 30); end
    else w(Q);
    s = sda_bus;
    w(Q);
    scl_m = 1'b0;
    w(Q);
  endtask

  task automatic do_start();
    sda_m = 1'b1; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl_m = 1'b0; w(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; w(Q); scl_m = 1'b1; w(Q); sda_m = 1'b1; w(2 * Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, input logic g, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], g, s);
    bit_x(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_x(1'b1, 1'b0, s); b[i] = s; end
    bit_x(~mack, 1'b0, s);
  endtask

  // write pointer + data list, checking every ACK
  task automatic wr_regs(input logic [7:0] dev, input logic [7:0] ptr,
                         input logic [7:0] d [], input string req);
    logic a;
    do_start();
    wr_byte(dev, 1'b0, a); chk(a, req, a, 1);
    wr_byte(ptr, 1'b0, a); chk(a, req, a, 1);
    foreach (d[i]) begin wr_byte(d[i], 1'b0, a); chk(a, req, a, 1); end
    do_stop();
  endtask

  // set pointer, repeated START, read n bytes and compare
  task automatic rd_regs(input logic [7:0] dev, input logic [7:0] ptr,
                         input logic [7:0] e [], input string req);
    logic a;
    logic [7:0] b;
    do_start();
    wr_byte(dev, 1'b0, a); chk(a, req, a, 1);
    wr_byte(ptr, 1'b0, a); chk(a, req, a, 1);
    do_start();
    wr_byte(dev | 8'h01, 1'b0, a); chk(a, req, a, 1);
    foreach (e[i]) begin
      rd_byte(i != e.size() - 1, b);
      chk(b == e[i], req, b, e[i]);
    end
    do_stop();
  endtask

  task automatic t_reset();
    chk(sda_drv_n == 1'b1, "R1 drive released", sda_drv_n, 1);
  endtask

  task automatic t_write_read();
    // R4 write, R7 + R5 read back via repeated START
    wr_regs(8'h74, 8'h02, '{8'hA5, 8'h3C, 8'hF0}, "R4");
    rd_regs(8'h74, 8'h02, '{8'hA5, 8'h3C, 8'hF0}, "R7 R5");
  endtask

  task automatic t_continue();
    logic a;
    logic [7:0] b;
    // pointer now 5 after three bytes read from 2; R1 reset value 0
    do_start();
    wr_byte(8'h75, 1'b0, a); chk(a, "R5 addr", a, 1);
    rd_byte(1'b1, b); chk(b == 8'h00, "R5 R1 continue reg5", b, 0);
    rd_byte(1'b0, b); chk(b == 8'h00, "R5 continue reg6", b, 0);
    do_stop();
  endtask

  task automatic t_mismatch();
    logic a;
    do_start();
    wr_byte(8'h76, 1'b0, a); chk(!a, "R3 no addr ack", a, 0);
    wr_byte(8'h00, 1'b0, a); chk(!a, "R3 no ptr ack", a, 0);
    wr_byte(8'h99, 1'b0, a); chk(!a, "R3 no data ack", a, 0);
    do_stop();
    rd_regs(8'h74, 8'h00, '{8'h00}, "R3 reg0 untouched");
  endtask

  task automatic t_sel();
    logic a;
    sel = 1'b1;
    w(10);
    wr_regs(8'h76, 8'h00, '{8'h11}, "R2 sel1 write");
    do_start();
    wr_byte(8'h74, 1'b0, a); chk(!a, "R2 old address ignored", a, 0);
    do_stop();
    rd_regs(8'h76, 8'h00, '{8'h11}, "R2 sel1 readback");
    sel = 1'b0;
    w(10);
  endtask

  task automatic t_nack();
    logic a, s;
    logic [7:0] b;
    int low = 0;
    do_start();
    wr_byte(8'h74, 1'b0, a); chk(a, "R6", a, 1);
    wr_byte(8'h02, 1'b0, a); chk(a, "R6", a, 1);
    do_start();
    wr_byte(8'h75, 1'b0, a); chk(a, "R6", a, 1);
    rd_byte(1'b0, b); chk(b == 8'hA5, "R6 byte", b, 8'hA5);
    for (int i = 0; i < 9; i++) begin bit_x(1'b1, 1'b0, s); if (!s) low++; end
    chk(low == 0 && sda_drv_n, "R6 silent after NACK", low, 0);
    do_stop();
  endtask

  task automatic t_stop_abort();
    logic a, s;
    do_start();
    wr_byte(8'h74, 1'b0, a); chk(a, "R8", a, 1);
    wr_byte(8'h07, 1'b0, a); chk(a, "R8", a, 1);
    for (int i = 0; i < 4; i++) bit_x(1'b1, 1'b0, s);
    do_stop();
    chk(sda_drv_n == 1'b1, "R8 idle released", sda_drv_n, 1);
    rd_regs(8'h74, 8'h07, '{8'h00}, "R8 partial not written");
  endtask

  task automatic t_glitch();
    logic a;
    do_start();
    wr_byte(8'h74, 1'b1, a); chk(a, "R9 addr glitched", a, 1);
    wr_byte(8'h08, 1'b1, a); chk(a, "R9 ptr glitched", a, 1);
    wr_byte(8'h5A, 1'b1, a); chk(a, "R9 data glitched", a, 1);
    do_stop();
    rd_regs(8'h74, 8'h08, '{8'h5A}, "R9 readback");
  endtask

  task automatic t_wrap();
    wr_regs(8'h74, 8'hFF, '{8'h77, 8'h88}, "R10 write wrap");
    rd_regs(8'h74, 8'h0F, '{8'h77, 8'h88}, "R10 read wrap");
    rd_regs(8'h74, 8'h10, '{8'h88}, "R10 upper bits ignored");
  endtask

  initial begin
    w(5);
    t_reset();
    rst_n = 1'b1;
    w(20);
    t_reset();
    t_write_read();
    t_continue();
    t_mismatch();
    t_sel();
    t_nack();
    t_stop_abort();
    t_glitch();
    t_wrap();
    chk(r11_viol == 0, "R11 drive changed with SCL high", r11_viol, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule